// File: doc/BRIEF.md
# Three-Domain Clock-Enable Divider

This block runs entirely on one base clock. From it, the block derives three enable strobe streams: one for a core domain, one for a bus domain and one for a peripheral domain. Each stream fires once every N base cycles. N comes from a fixed lookup table and is indexed by a 3-bit select field in a writable frequency-control word. The core and bus domains share one table, which includes the odd ratios 3 and 5. The peripheral domain has its own table, which includes 3 and 6. Logic in each domain samples its enable instead of running on a divided clock. No clock is gated, muxed or switched.

A small register port writes and reads the control word. The same port also reaches two scratch words kept for watchdog settings. These two words are stored and read back but have no effect on any strobe. For each domain the block also reports the ratio in force, so that other logic can scale time-based values.

Each domain is a two-state machine. In state BYPASS the active ratio is 1 and the strobe is high on every cycle. In state DIVIDE a counter runs from 0 up to ratio−1 and the strobe fires on the last count. Both states leave only at a wrap, meaning the last count of a period. At a wrap the domain loads the ratio now selected. It takes the transition to BYPASS when that ratio is 1 and the transition to DIVIDE otherwise. Between wraps it stays in its current state.

Top module: `cken_divider`

## Requirements
- R1: The core ratio is selected by control bits 8:6, with codes 0..7 giving ratios 1, 2, 3, 4, 5, 8, 8, 8.
- R2: The bus ratio is selected by control bits 5:3, using the same table as the core ratio.
- R3: The peripheral ratio is selected by control bits 2:0, with codes 0..7 giving ratios 2, 3, 4, 6, 8, 8, 8, 8.
- R4: After reset the control word reads 0 and `cpu_en` and `bus_en` are high on every cycle. `per_en` is low in the first cycle after reset release, high in the second, and high on every second cycle after that. The reported ratios are 1, 1 and 2.
- R5: With an active ratio N, a domain's strobe is high for exactly one cycle in every N cycles.
- R6: A new ratio takes effect only at the domain's next wrap. The period in progress when the write lands keeps its old length.
- R7: While a domain's active ratio is 1, its strobe is high on every cycle.
- R8: Address 0 holds the control word. A read returns the last value written to it, with all 16 bits kept.
- R9: Addresses 1 and 2 hold watchdog words. They read back as written and have no effect on any strobe or reported ratio.
- R10: `cpu_ratio`, `bus_ratio` and `per_ratio` report the ratio the matching domain is counting with at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register address (0 control, 1 and 2 watchdog) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register (combinational) |
| cpu_en | output | 1 | Core domain enable strobe |
| bus_en | output | 1 | Bus domain enable strobe |
| per_en | output | 1 | Peripheral domain enable strobe |
| cpu_ratio | output | 4 | Active core ratio |
| bus_ratio | output | 4 | Active bus ratio |
| per_ratio | output | 4 | Active peripheral ratio |

## Verification
A register write lands at the clock edge where `reg_we` is sampled, so read data reflects it one cycle later. Read data itself is combinational and is sampled 1 ns after the address is driven. A written ratio is first used at the edge that follows the domain's next strobe cycle. The bench therefore samples every output on the falling edge. On each strobe it checks the gap since the previous strobe against the ratio it expects to be active, then switches its expectation to the ratio selected by the control word visible in that same cycle. The old-period-preserved case is measured by counting falling edges from the strobe before a mid-period write to the strobe after it.

// File: rtl/cken_pkg.sv
package cken_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 2;
    localparam int SEL_W   = 3;
    localparam int RATIO_W = 4;
    localparam int N_DOM   = 3;

    typedef enum logic [0:0] {
        ST_BYPASS = 1'b0,
        ST_DIVIDE = 1'b1
    } dom_state_t;

    // core and bus table
    function automatic logic [RATIO_W-1:0] core_ratio(input logic [SEL_W-1:0] code);
        logic [RATIO_W-1:0] r;
        case (code)
            3'd0:    r = RATIO_W'(1);
            3'd1:    r = RATIO_W'(2);
            3'd2:    r = RATIO_W'(3);
            3'd3:    r = RATIO_W'(4);
            3'd4:    r = RATIO_W'(5);
            default: r = RATIO_W'(8);
        endcase
        return r;
    endfunction

    // peripheral table
    function automatic logic [RATIO_W-1:0] periph_ratio(input logic [SEL_W-1:0] code);
        logic [RATIO_W-1:0] r;
        case (code)
            3'd0:    r = RATIO_W'(2);
            3'd1:    r = RATIO_W'(3);
            3'd2:    r = RATIO_W'(4);
            3'd3:    r = RATIO_W'(6);
            default: r = RATIO_W'(8);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cken_regs.sv
module cken_regs
    import cken_pkg::*;
#(
    parameter int DW     = DATA_W,
    parameter int AW     = ADDR_W,
    parameter int N_REGS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctrl_q,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] store_q [N_REGS];

    for (genvar g = 0; g < N_REGS; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                store_q[g] <= '0;
            end else if (we && (addr == AW'(g))) begin
                store_q[g] <= wdata;
            end
        end
    end

    assign ctrl_q = store_q[0];

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_REGS; i++) begin
            if (addr == AW'(i)) rdata = store_q[i];
        end
    end

    // R8
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == '0) |=> (ctrl_q == $past(wdata)));

endmodule

// File: rtl/cken_domain.sv
module cken_domain
    import cken_pkg::*;
#(
    parameter int RW        = RATIO_W,
    parameter int SW        = SEL_W,
    parameter bit IS_PERIPH = 1'b0,
    parameter int RST_RATIO = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] sel,
    output logic          en_o,
    output logic [RW-1:0] ratio_o
);

    localparam logic [RW-1:0] RST_R = RW'(RST_RATIO);
    localparam logic [RW-1:0] ONE   = RW'(1);

    dom_state_t     state_q;
    logic [RW-1:0]  act_q;
    logic [RW-1:0]  cnt_q;
    logic [RW-1:0]  req;
    logic           wrap;

    if (IS_PERIPH) begin : g_per
        assign req = periph_ratio(sel);
    end else begin : g_core
        assign req = core_ratio(sel);
    end

    assign wrap = (cnt_q == act_q - ONE);

    // state register, active ratio and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= (RST_R == ONE) ? ST_BYPASS : ST_DIVIDE;
            act_q   <= RST_R;
            cnt_q   <= '0;
        end else if (wrap) begin
            state_q <= (req == ONE) ? ST_BYPASS : ST_DIVIDE;
            act_q   <= req;
            cnt_q   <= '0;
        end else begin
            cnt_q   <= cnt_q + ONE;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_BYPASS: en_o = 1'b1;
            ST_DIVIDE: en_o = wrap;
            default:   en_o = 1'b0;
        endcase
    end

    assign ratio_o = act_q;

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < act_q);
    // R5
    pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && req != ONE) |=> !en_o);
    // R6
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |=> $stable(ratio_o));
    // R7
    bypass_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_o == ONE) |-> en_o);

endmodule

// File: rtl/cken_divider.sv
module cken_divider
    import cken_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int RW = RATIO_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          cpu_en,
    output logic          bus_en,
    output logic          per_en,
    output logic [RW-1:0] cpu_ratio,
    output logic [RW-1:0] bus_ratio,
    output logic [RW-1:0] per_ratio
);

    localparam int SEL_BITS = N_DOM * SEL_W;

    logic [DW-1:0] ctrl;
    logic          en_v    [N_DOM];
    logic [RW-1:0] ratio_v [N_DOM];

    cken_regs #(.DW(DW), .AW(AW), .N_REGS(3)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .ctrl_q (ctrl),
        .rdata  (reg_rdata)
    );

    // domain 0 core (bits 8:6), 1 bus (5:3), 2 peripheral (2:0)
    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        localparam int LSB = SEL_BITS - SEL_W * (d + 1);
        cken_domain #(
            .RW        (RW),
            .SW        (SEL_W),
            .IS_PERIPH (d == N_DOM - 1),
            .RST_RATIO ((d == N_DOM - 1) ? 2 : 1)
        ) u_dom (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (ctrl[LSB +: SEL_W]),
            .en_o    (en_v[d]),
            .ratio_o (ratio_v[d])
        );
    end

    assign cpu_en    = en_v[0];
    assign bus_en    = en_v[1];
    assign per_en    = en_v[2];
    assign cpu_ratio = ratio_v[0];
    assign bus_ratio = ratio_v[1];
    assign per_ratio = ratio_v[2];

endmodule

// File: tb/cken_divider_tb_top.sv
module cken_divider_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cpu_en, bus_en, per_en;
    logic [3:0]  cpu_ratio, bus_ratio, per_ratio;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    cken_divider dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_en(cpu_en), .bus_en(bus_en), .per_en(per_en),
        .cpu_ratio(cpu_ratio), .bus_ratio(bus_ratio), .per_ratio(per_ratio)
    );

    function automatic int core_r(input int c);
        return (c < 5) ? c + 1 : 8;
    endfunction
    function automatic int per_r(input int c);
        return (c < 2) ? c + 2 : (c < 4) ? 2 * c : 8;
    endfunction

    logic [15:0] model_ctrl = '0;
    bit          mon_on = 1'b0;
    int          cyc = 0;
    int          exp_act [3] = '{1, 1, 2};
    int          last_p  [3] = '{0, 0, 0};
    bit          seen    [3] = '{0, 0, 0};

    task automatic check(input string req, input int act, input int expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // continuous strobe monitor: R5 R6 R10
    always @(negedge clk) begin
        if (mon_on) begin
            cyc++;
            for (int d = 0; d < 3; d++) begin
                logic en;
                int   rp;
                en = (d == 0) ? cpu_en : (d == 1) ? bus_en : per_en;
                rp = (d == 0) ? int'(cpu_ratio) : (d == 1) ? int'(bus_ratio) : int'(per_ratio);
                if (en) begin
                    if (seen[d]) check("R5 R6 gap", cyc - last_p[d], exp_act[d]);
                    check("R10 ratio port", rp, exp_act[d]);
                    exp_act[d] = (d == 0) ? core_r(int'(model_ctrl[8:6])) :
                                 (d == 1) ? core_r(int'(model_ctrl[5:3])) :
                                            per_r(int'(model_ctrl[2:0]));
                    last_p[d] = cyc;
                    seen[d] = 1'b1;
                end
            end
        end
    end

    // called just after a falling edge
    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
        if (a == 2'd0) model_ctrl = v;
        @(negedge clk);
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input logic [15:0] expv);
        reg_addr = a;
        #1;
        check(req, int'(reg_rdata), int'(expv));
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        logic [3:0] sc, sb, sp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        #1;
        // R4: first cycle after release
        check("R4 cpu_en", int'(cpu_en), 1);
        check("R4 bus_en", int'(bus_en), 1);
        check("R4 per_en first", int'(per_en), 0);
        check("R4 ratios", {cpu_ratio, bus_ratio, per_ratio}, 12'h112);
        check("R4 ctrl read", int'(reg_rdata), 0);
        @(negedge clk);
        #1;
        check("R4 per_en second", int'(per_en), 1);
        @(negedge clk);
        repeat (6) @(negedge clk);

        // sweep all codes on all three fields at once
        for (int k = 0; k < 8; k++) begin
            wr(2'd0, 16'((k << 6) | (k << 3) | k));
            repeat (30) @(negedge clk);
            #1;
            check("R1 core ratio", int'(cpu_ratio), core_r(k));
            check("R2 bus ratio", int'(bus_ratio), core_r(k));
            check("R3 per ratio", int'(per_ratio), per_r(k));
            if (k == 0) begin
                n = 0;
                for (int j = 0; j < 10; j++) begin
                    if (cpu_en && bus_en) n++;
                    @(negedge clk);
                    #1;
                end
                check("R7 held high", n, 10);
            end
            @(negedge clk);
        end

        // mixed fields
        for (int i = 0; i < 8; i++) begin
            wr(2'd0, 16'((i << 6) | ((7 - i) << 3) | ((3 * i) % 8)));
            repeat (30) @(negedge clk);
            #1;
            check("R1 mixed", int'(cpu_ratio), core_r(i));
            check("R2 mixed", int'(bus_ratio), core_r(7 - i));
            check("R3 mixed", int'(per_ratio), per_r((3 * i) % 8));
            @(negedge clk);
        end

        // R6: switch periph from 8 to 2 three cycles into a period
        wr(2'd0, 16'h0004);
        repeat (20) @(negedge clk);
        while (!per_en) @(negedge clk);
        n = 0;
        repeat (3) begin @(negedge clk); n++; end
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0000;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
        model_ctrl = 16'h0000;
        do begin @(negedge clk); n++; end while (!per_en);
        check("R6 old period kept", n, 8);
        n = 0;
        do begin @(negedge clk); n++; end while (!per_en);
        check("R6 new period", n, 2);

        // R8: full-width readback
        wr(2'd0, 16'hF1A3);
        rd_check("R8 ctrl readback", 2'd0, 16'hF1A3);
        repeat (20) @(negedge clk);
        #1;
        check("R1 from F1A3", int'(cpu_ratio), 8);
        check("R2 from F1A3", int'(bus_ratio), 5);
        check("R3 from F1A3", int'(per_ratio), 6);
        sc = cpu_ratio; sb = bus_ratio; sp = per_ratio;
        @(negedge clk);

        // R9: watchdog words stored, no effect
        wr(2'd1, 16'h5A5A);
        wr(2'd2, 16'h00C3);
        rd_check("R9 wd word 1", 2'd1, 16'h5A5A);
        rd_check("R9 wd word 2", 2'd2, 16'h00C3);
        rd_check("R9 ctrl untouched", 2'd0, 16'hF1A3);
        repeat (20) @(negedge clk);
        #1;
        check("R9 ratios unchanged", {sc, sb, sp}, {cpu_ratio, bus_ratio, per_ratio});
        @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule